// File: doc/BRIEF.md
# Dual-FIFO Host Data Port with DMA Request Handshake

This block is the host-facing data window of a network buffer. One register offset carries all packet data. A host write at that offset goes into a transmit FIFO, and a host read at that offset takes data from a receive FIFO. The two directions have separate storage, so the host never has to set a direction and may mix reads and writes freely. On the far side, the buffer memory logic drains the transmit FIFO and fills the receive FIFO through plain push/pop ports.

Data can be moved by programmed I/O or by an external DMA controller. The port raises a request line when the selected FIFO can take or give data. The controller answers with an acknowledge, and the acknowledge selects the port by itself, with no address decode. Two pacing modes exist. In single mode the request drops after every acknowledged cycle. In burst mode it stays up until the FIFO runs out. A terminate input from the controller ends the DMA run after the current cycle and, if enabled, raises an interrupt. The port works either 16 bits wide or 8 bits wide (byte lanes).

Top module: `buf_data_port`

## Requirements
- R1: A host access reaches the port only when `host_cs` is high and `host_addr` equals `PORT_OFS` (default 8). A write at any other offset leaves the transmit FIFO unchanged. A read at any other offset neither pops the receive FIFO nor changes `host_rdata`.
- R2: Port writes enter the transmit FIFO in order. `tx_valid` is high when the FIFO holds data, `tx_data` shows the oldest entry, and `tx_pop` removes that entry.
- R3: A port read pops the oldest receive entry, which appears on `host_rdata` after the next rising clock edge. `host_rdata` keeps its value when there is no port read. `rx_push` with `rx_data` appends to the receive FIFO while `rx_ready` is high.
- R4: A port write and a port read in the same cycle both take effect.
- R5: When `dack` is high, the port is selected whatever the values of `host_cs` and `host_addr`.
- R6: When `byte_mode` is 1, bits 15:8 of a written word are stored as zero, and bits 15:8 of read data are returned as zero.
- R7: `dreq` is low whenever `dma_en` is low. With `dma_en`=1 and `dma_burst`=0, `dreq` is high while the selected FIFO can serve. It falls in the cycle after each acknowledged transfer (`dack` with a strobe) and returns one cycle later. `dma_dir`=0 selects transmit (not full); `dma_dir`=1 selects receive (not empty).
- R8: With `dma_burst`=1, `dreq` stays high across acknowledged transfers. It falls only when the selected FIFO becomes full (transmit) or empty (receive).
- R9: An acknowledged transfer with `eop` high still completes. From the next cycle `dreq` stays low until `dma_en` is taken low.
- R10: `irq` is high exactly when the DMA run has been terminated by `eop` and `dma_irq_en` is 1.
- R11: A port read of an empty receive FIFO returns zero and sets `rx_unf`. The flag stays set until reset.
- R12: A port write to a full transmit FIFO is discarded and sets `tx_ovf`. The flag stays set until reset.
- R13: After reset both FIFOs are empty, `rx_ready` is 1, and `dreq`, `irq`, `tx_ovf` and `rx_unf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host chip select |
| host_addr | input | ADDR_W | Host register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| byte_mode | input | 1 | 1 = 8-bit lanes, 0 = full width |
| dack | input | 1 | DMA acknowledge, selects the port |
| eop | input | 1 | DMA terminate, valid with an acknowledged cycle |
| dma_en | input | 1 | DMA run enable |
| dma_burst | input | 1 | 1 = burst pacing, 0 = single pacing |
| dma_dir | input | 1 | 0 = transmit, 1 = receive |
| dma_irq_en | input | 1 | Interrupt enable for DMA completion |
| dreq | output | 1 | DMA request |
| irq | output | 1 | DMA completion interrupt |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| tx_pop | input | 1 | Buffer side takes the transmit head |
| tx_data | output | DATA_W | Transmit head entry |
| tx_valid | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Buffer side appends a receive entry |
| rx_data | input | DATA_W | Receive entry to append |
| rx_ready | output | 1 | Receive FIFO not full |

## Verification
Some rules are checked on every cycle. The request line is held low while DMA is off, it falls after each single-mode acknowledge, and it stays low after a terminate. The interrupt never rises while its enable is low. A read of an empty FIFO yields zero and sets the underflow flag, a write to a full FIFO sets the overflow flag, and both flags, once set, stay set. Other behaviour only shows in the bench's scenarios: data order through each FIFO, the offset and acknowledge selection, byte-lane masking, same-cycle read/write mixing, burst pacing draining to empty, and whether a discarded write really left the FIFO contents alone.

// File: rtl/buf_port_pkg.sv
// Shared definitions for the host data port.
// Assumes: a single DMA direction is active at a time.
package buf_port_pkg;
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dma_dir_e;
endpackage

// File: rtl/bp_fifo.sv
// Synchronous FIFO with a head view (first-word fall-through).
// A push while full and a pop while empty are ignored internally.
// Assumes DEPTH >= 2.
module bp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign head    = mem[rp];

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/bp_dreq_ctrl.sv
// DMA request pacing and terminate tracking.
// Single mode leaves one idle cycle after every acknowledged transfer;
// burst mode requests as long as the selected FIFO can serve.
// Assumes xfer is high only in cycles with dack and a strobe.
module bp_dreq_ctrl
    import buf_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic dma_burst,
    input  logic dma_dir,
    input  logic dma_irq_en,
    input  logic xfer,
    input  logic eop,
    input  logic tx_full,
    input  logic rx_empty,
    output logic dreq,
    output logic irq
);
    logic gap;
    logic done;
    logic avail;

    // Selected FIFO can serve one more DMA cycle
    assign avail = (dma_dir == DIR_RX) ? ~rx_empty : ~tx_full;

    // Single-mode gap after an acknowledged cycle
    always_ff @(posedge clk) begin
        if (!rst_n) gap <= 1'b0;
        else        gap <= xfer & ~dma_burst;
    end

    // Terminate latch, released by disabling DMA
    always_ff @(posedge clk) begin
        if (!rst_n)          done <= 1'b0;
        else if (!dma_en)    done <= 1'b0;
        else if (xfer & eop) done <= 1'b1;
    end

    assign dreq = dma_en & ~done & avail & ~gap;
    assign irq  = done & dma_irq_en;
endmodule

// File: rtl/buf_data_port.sv
// Host data port: one offset, a transmit FIFO for writes and a receive
// FIFO for reads, with DMA request/acknowledge pacing.
// Assumes one-cycle host strobes and DATA_W >= 16.
module buf_data_port #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int PORT_OFS = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              byte_mode,
    input  logic              dack,
    input  logic              eop,
    input  logic              dma_en,
    input  logic              dma_burst,
    input  logic              dma_dir,
    input  logic              dma_irq_en,
    output logic              dreq,
    output logic              irq,
    output logic              tx_ovf,
    output logic              rx_unf,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready
);
    localparam logic [ADDR_W-1:0] OFS       = ADDR_W'(PORT_OFS);
    localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'(8'hFF);

    logic              sel, wr_acc, rd_acc, xfer;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head, wr_lane, rd_lane;

    assign sel    = dack | (host_cs & (host_addr == OFS));
    assign wr_acc = sel & host_wr;
    assign rd_acc = sel & host_rd;
    assign xfer   = dack & (host_wr | host_rd);

    assign wr_lane = byte_mode ? (host_wdata & BYTE_MASK) : host_wdata;
    assign rd_lane = byte_mode ? (rx_head & BYTE_MASK) : rx_head;

    assign tx_valid = ~tx_empty;
    assign rx_ready = ~rx_full;

    bp_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_acc), .wdata(wr_lane),
        .pop(tx_pop), .head(tx_data),
        .empty(tx_empty), .full(tx_full)
    );

    bp_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_data),
        .pop(rd_acc), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    bp_dreq_ctrl i_dreq (
        .clk(clk), .rst_n(rst_n),
        .dma_en(dma_en), .dma_burst(dma_burst), .dma_dir(dma_dir),
        .dma_irq_en(dma_irq_en), .xfer(xfer), .eop(eop),
        .tx_full(tx_full), .rx_empty(rx_empty),
        .dreq(dreq), .irq(irq)
    );

    // Registered read data, zero on underflow, held when idle
    always_ff @(posedge clk) begin
        if (!rst_n)      host_rdata <= '0;
        else if (rd_acc) host_rdata <= rx_empty ? '0 : rd_lane;
    end

    // Sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            if (wr_acc & tx_full)  tx_ovf <= 1'b1;
            if (rd_acc & rx_empty) rx_unf <= 1'b1;
        end
    end
endmodule

// File: rtl/buf_data_port_chk.sv
// Cycle-by-cycle property checker for the host data port.
module buf_data_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              dack,
    input logic              eop,
    input logic              dma_en,
    input logic              dma_burst,
    input logic              dma_irq_en,
    input logic              dreq,
    input logic              irq,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_ovf,
    input logic              rx_unf
);
    // R7
    dreq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dreq);

    // R7
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !dma_burst && dack && (host_wr || host_rd)) |=> !dreq);

    // R9
    eop_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dack && (host_wr || host_rd) && eop) |=> !dreq);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dma_irq_en);

    // R11
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && host_rd && rx_empty) |=> (host_rdata == '0 && rx_unf));

    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unf |=> rx_unf);

    // R12
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && host_wr && tx_full) |=> tx_ovf);

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);
endmodule

bind buf_data_port buf_data_port_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .dack(dack), .eop(eop), .dma_en(dma_en), .dma_burst(dma_burst),
    .dma_irq_en(dma_irq_en), .dreq(dreq), .irq(irq),
    .tx_full(tx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/test_buf_data_port.sv
// Self-checking bench: table walk for the main data path, then directed
// scenarios for selection, byte lanes, overflow and DMA pacing.
module test_buf_data_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        byte_mode = 1'b0, dack = 1'b0, eop = 1'b0;
    logic        dma_en = 1'b0, dma_burst = 1'b0, dma_dir = 1'b0, dma_irq_en = 1'b0;
    logic        dreq, irq, tx_ovf, rx_unf;
    logic        tx_pop = 1'b0, tx_valid, rx_push = 1'b0, rx_ready;
    logic [15:0] tx_data, rx_data = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    buf_data_port i_buf_data_port (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .byte_mode(byte_mode), .dack(dack), .eop(eop),
        .dma_en(dma_en), .dma_burst(dma_burst), .dma_dir(dma_dir),
        .dma_irq_en(dma_irq_en), .dreq(dreq), .irq(irq), .tx_ovf(tx_ovf),
        .rx_unf(rx_unf), .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_push(rx_push), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RXP = 2'd2, OP_TXP = 2'd3;
    localparam int NVEC = 13;
    // {op, addr, data, expected}
    localparam logic [37:0] VEC [NVEC] = '{
        {OP_WR,  4'h8, 16'h1111, 16'h0000},   // R2
        {OP_WR,  4'h8, 16'h2222, 16'h0000},   // R2
        {OP_WR,  4'h5, 16'h3333, 16'h0000},   // R1 wrong offset
        {OP_TXP, 4'h0, 16'h0000, 16'h1111},   // R2
        {OP_TXP, 4'h0, 16'h0000, 16'h2222},   // R2, R1 (no 3333 after)
        {OP_RXP, 4'h0, 16'hAAAA, 16'h0000},   // R3
        {OP_RXP, 4'h0, 16'hBBBB, 16'h0000},   // R3
        {OP_RD,  4'h8, 16'h0000, 16'hAAAA},   // R3
        {OP_RD,  4'h3, 16'h0000, 16'hAAAA},   // R1 read elsewhere holds
        {OP_RD,  4'h8, 16'h0000, 16'hBBBB},   // R3
        {OP_RD,  4'h8, 16'h0000, 16'h0000},   // R11 empty read
        {OP_WR,  4'h8, 16'h4444, 16'h0000},   // R2
        {OP_TXP, 4'h0, 16'h0000, 16'h4444}    // R2
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic cs, input logic [3:0] a, input logic w,
                           input logic r, input logic [15:0] d);
        @(negedge clk);
        host_cs = cs; host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic dma_op(input logic w, input logic r, input logic [15:0] d, input logic e);
        @(negedge clk);
        dack = 1'b1; host_cs = 1'b0; host_addr = 4'h0;
        host_wr = w; host_rd = r; host_wdata = d; eop = e;
        @(negedge clk);
        dack = 1'b0; host_wr = 1'b0; host_rd = 1'b0; eop = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx(input string req, input logic [15:0] exp);
        @(negedge clk);
        check(req, {15'd0, tx_valid}, 16'd1);
        check(req, tx_data, exp);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R13 rx_ready", {15'd0, rx_ready}, 16'd1);
        check("R13 dreq/irq", {14'd0, dreq, irq}, 16'd0);
        check("R13 flags", {14'd0, tx_ovf, rx_unf}, 16'd0);

        // Table walk: main data path
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][37:36])
                OP_WR:  host_op(1'b1, VEC[i][35:32], 1'b1, 1'b0, VEC[i][31:16]);
                OP_RD: begin
                    host_op(1'b1, VEC[i][35:32], 1'b0, 1'b1, 16'h0);
                    check($sformatf("R3/R1/R11 vec %0d rdata", i), host_rdata, VEC[i][15:0]);
                end
                OP_RXP: push_rx(VEC[i][31:16]);
                default: pop_tx($sformatf("R2/R1 vec %0d tx", i), VEC[i][15:0]);
            endcase
        end
        @(negedge clk);
        check("R2 tx drained", {15'd0, tx_valid}, 16'd0);
        check("R11 rx_unf sticky", {15'd0, rx_unf}, 16'd1);

        // R4 read and write in one cycle
        push_rx(16'h5555);
        host_op(1'b1, 4'h8, 1'b1, 1'b1, 16'h6666);
        check("R4 rdata", host_rdata, 16'h5555);
        pop_tx("R4 tx", 16'h6666);

        // R5 acknowledge selects without address
        dma_op(1'b1, 1'b0, 16'h9999, 1'b0);
        pop_tx("R5 tx", 16'h9999);

        // R6 byte lanes
        byte_mode = 1'b1;
        host_op(1'b1, 4'h8, 1'b1, 1'b0, 16'hABCD);
        pop_tx("R6 write lane", 16'h00CD);
        push_rx(16'h1234);
        host_op(1'b1, 4'h8, 1'b0, 1'b1, 16'h0);
        check("R6 read lane", host_rdata, 16'h0034);
        byte_mode = 1'b0;

        // R12 overflow discards the extra write
        for (int k = 0; k < 8; k++) host_op(1'b1, 4'h8, 1'b1, 1'b0, 16'h0100 + 16'(k));
        check("R12 no ovf yet", {15'd0, tx_ovf}, 16'd0);
        host_op(1'b1, 4'h8, 1'b1, 1'b0, 16'hDEAD);
        check("R12 ovf set", {15'd0, tx_ovf}, 16'd1);
        for (int k = 0; k < 8; k++) pop_tx("R12 contents", 16'h0100 + 16'(k));
        @(negedge clk);
        check("R12 extra dropped", {15'd0, tx_valid}, 16'd0);
        check("R12 ovf sticky", {15'd0, tx_ovf}, 16'd1);

        // R7 single pacing, transmit direction
        @(negedge clk);
        check("R7 idle dreq", {15'd0, dreq}, 16'd0);
        dma_dir = 1'b0; dma_burst = 1'b0; dma_en = 1'b1;
        @(negedge clk);
        check("R7 dreq up", {15'd0, dreq}, 16'd1);
        dma_op(1'b1, 1'b0, 16'h0A0A, 1'b0);
        check("R7 dreq gap", {15'd0, dreq}, 16'd0);
        @(negedge clk);
        check("R7 dreq back", {15'd0, dreq}, 16'd1);
        dma_en = 1'b0;
        pop_tx("R7 tx", 16'h0A0A);

        // R8 burst pacing, receive direction
        push_rx(16'hC001);
        push_rx(16'hC002);
        dma_dir = 1'b1; dma_burst = 1'b1; dma_en = 1'b1;
        @(negedge clk);
        check("R8 dreq up", {15'd0, dreq}, 16'd1);
        dma_op(1'b0, 1'b1, 16'h0, 1'b0);
        check("R8 first", host_rdata, 16'hC001);
        check("R8 dreq held", {15'd0, dreq}, 16'd1);
        dma_op(1'b0, 1'b1, 16'h0, 1'b0);
        check("R8 second", host_rdata, 16'hC002);
        check("R8 dreq empty", {15'd0, dreq}, 16'd0);
        dma_en = 1'b0;

        // R9 / R10 terminate
        @(negedge clk);
        dma_dir = 1'b0; dma_burst = 1'b1; dma_irq_en = 1'b1; dma_en = 1'b1;
        @(negedge clk);
        check("R10 irq before eop", {15'd0, irq}, 16'd0);
        dma_op(1'b1, 1'b0, 16'h7777, 1'b1);
        check("R9 dreq stop", {15'd0, dreq}, 16'd0);
        check("R10 irq", {15'd0, irq}, 16'd1);
        check("R9 last cycle done", tx_data, 16'h7777);
        @(negedge clk);
        check("R9 dreq stays low", {15'd0, dreq}, 16'd0);
        dma_irq_en = 1'b0;
        #1;
        check("R10 irq masked", {15'd0, irq}, 16'd0);
        dma_en = 1'b0;
        pop_tx("R9 tx", 16'h7777);
        @(negedge clk);
        dma_en = 1'b1;
        @(negedge clk);
        check("R9 re-enable", {15'd0, dreq}, 16'd1);
        dma_en = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule